// File: doc/BRIEF.md
# Boot Source Probe Sequencer

This controller runs once after reset and settles where the chip should load its first image from. It releases each candidate pin of a small bidirectional pin group, waits a settle time set by software-free input, and looks for an external pull-up. Candidates are tried in a fixed order: serial input, two-wire EEPROM clock, SPI flash chip select, then SD card chip select. If none answers, a serial/debug fallback is chosen. When a flash chip select is found, the sequencer holds that select low and probes the two possible data hookups, so that a shared data-in/data-out wiring (3-pin) is told apart from a wiring with a separate data-in pin (4-pin).

The result is a one-hot source vector, a flash width flag and a done flag. The result stays fixed until the next reset. Reading the image and speaking the device protocols belong to the blocks that consume this result.

Top module: `boot_probe_seq`

## Requirements
- R1: With the serial pin (pin 7) pulled up, the serial source (src_o bit 0) is chosen whatever the other pins read.
- R2: With pin 7 low and the EEPROM clock pin (pin 6) pulled up, the EEPROM source (src_o bit 1) is chosen.
- R3: With pin 5 (flash select) pulled up and the joined data pin (pin 4) answering, the flash source (src_o bit 2) is chosen with width4_o = 0. The joined pin is tried before the separate pin. Data pins are ignored when pin 5 is not pulled up.
- R4: With pin 5 pulled up and only the separate data-in pin (pin 3) answering, flash is chosen with width4_o = 1. width4_o is never 1 without the flash source.
- R5: With pin 5 pulled up and neither data pin answering, flash is rejected and the SD test follows.
- R6: When no earlier source is accepted and the SD select pin (pin 2) is pulled up, the SD source (src_o bit 3) is chosen.
- R7: When no pull-up is accepted, the debug fallback (src_o bit 4) is chosen.
- R8: pin_do_o is always 0. The only pin ever driven (pin_oe_o) is pin 5, and only while a flash data pin is being probed. No pin is driven in idle or once done.
- R9: Each probe step lasts settle_i + 1 + CONFIRM_GAP cycles (settle_i captured at start). done_o rises exactly steps × that count cycles after the clock edge that takes start_i.
- R10: A pin counts as pulled up only if it reads high at the end of the settle time and again CONFIRM_GAP cycles later. A high at only one of the two samples is rejected.
- R11: When done_o is high, exactly one src_o bit is set; src_o is zero before that. The result and done_o hold, and start_i is ignored, until reset.
- R12: In reset, done_o, src_o, width4_o and pin_oe_o are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Pulse that begins the probe run |
| settle_i | input | SETTLE_W | Settle cycles before the first sample of each step |
| pin_i | input | NUM_PINS | Sampled pin levels |
| pin_oe_o | output | NUM_PINS | Per-pin output enable |
| pin_do_o | output | NUM_PINS | Per-pin drive value |
| src_o | output | 5 | One-hot boot source: 0 serial, 1 EEPROM, 2 flash, 3 SD, 4 debug |
| width4_o | output | 1 | Flash hookup: 0 = 3-pin, 1 = 4-pin |
| done_o | output | 1 | Result valid and held |

## Verification
A wrong step index or a wrong pin selection shows at the ports as a different source or width once done_o rises, and a skipped or repeated step shows as a done latency off by a whole step length, so each run is judged on the exact cycle of done_o. A broken sample latch or gap counter shows only under a pulse that lasts one sample, so short highs are placed on the first and on the second sample. A wrong drive decode shows within the first cycle of the flash data steps on pin_oe_o.

// File: rtl/boot_probe_pkg.sv
package boot_probe_pkg;
  typedef enum logic [2:0] {
    STEP_SER, STEP_EEP, STEP_FCS, STEP_FJOIN, STEP_FSEP, STEP_SDCS
  } step_e;

  typedef enum logic [1:0] {PH_IDLE, PH_SETTLE, PH_GAP, PH_DONE} phase_e;

  localparam int unsigned SRC_W = 5;
  localparam logic [2:0] SRC_SER   = 3'd0;
  localparam logic [2:0] SRC_EEP   = 3'd1;
  localparam logic [2:0] SRC_FLASH = 3'd2;
  localparam logic [2:0] SRC_SD    = 3'd3;
  localparam logic [2:0] SRC_DBG   = 3'd4;
endpackage

// File: rtl/bp_step_timer.sv
module bp_step_timer #(
  parameter int SETTLE_W = 8,
  parameter int GAP      = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                clr_i,
  input  logic                in_settle_i,
  input  logic                in_gap_i,
  input  logic [SETTLE_W-1:0] settle_lim_i,
  output logic                s1_o,
  output logic                s2_o
);
  localparam int GAP_W = $clog2(GAP + 1);
  localparam int CNT_W = (SETTLE_W > GAP_W) ? SETTLE_W : GAP_W;

  logic [CNT_W-1:0] cnt_q;

  assign s1_o = in_settle_i && (cnt_q >= CNT_W'(settle_lim_i));
  assign s2_o = in_gap_i && (cnt_q == CNT_W'(GAP - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     cnt_q <= '0;
    else if (clr_i || s1_o || s2_o)  cnt_q <= '0;
    else if (in_settle_i || in_gap_i) cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/bp_pull_confirm.sv
module bp_pull_confirm (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic s1_i,
  input  logic pin_i,
  output logic hit_o
);
  logic first_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   first_q <= 1'b0;
    else if (s1_i) first_q <= pin_i;
  end

  // second sample is the live level at the gap strobe
  assign hit_o = first_q & pin_i;
endmodule

// File: rtl/bp_pin_drive.sv
module bp_pin_drive #(
  parameter int NUM_PINS = 8,
  parameter int PIN_FCS  = 5
) (
  input  logic                drive_fcs_i,
  output logic [NUM_PINS-1:0] oe_o,
  output logic [NUM_PINS-1:0] do_o
);
  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    if (i == PIN_FCS) begin : g_fcs
      assign oe_o[i] = drive_fcs_i;  // select held low during data probe
    end else begin : g_free
      assign oe_o[i] = 1'b0;
    end
    assign do_o[i] = 1'b0;
  end
endmodule

// File: rtl/boot_probe_seq.sv
module boot_probe_seq
  import boot_probe_pkg::*;
#(
  parameter int NUM_PINS    = 8,
  parameter int SETTLE_W    = 8,
  parameter int CONFIRM_GAP = 4,
  parameter int PIN_SER     = 7,
  parameter int PIN_CLK     = 6,
  parameter int PIN_FCS     = 5,
  parameter int PIN_DJOIN   = 4,
  parameter int PIN_DSEP    = 3,
  parameter int PIN_SDCS    = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  logic [SETTLE_W-1:0] settle_i,
  input  logic [NUM_PINS-1:0] pin_i,
  output logic [NUM_PINS-1:0] pin_oe_o,
  output logic [NUM_PINS-1:0] pin_do_o,
  output logic [SRC_W-1:0]    src_o,
  output logic                width4_o,
  output logic                done_o
);
  localparam int PIN_IW = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1;

  phase_e              phase_q;
  step_e               step_q, nxt_step;
  logic [SETTLE_W-1:0] settle_q;
  logic [SRC_W-1:0]    src_q;
  logic                width_q;
  logic [PIN_IW-1:0]   tgt;
  logic                s1, s2, hit, fin, fin_w, go;
  logic [2:0]          fin_src;

  assign go = (phase_q == PH_IDLE) && start_i;

  always_comb begin
    unique case (step_q)
      STEP_SER:   tgt = PIN_IW'(PIN_SER);
      STEP_EEP:   tgt = PIN_IW'(PIN_CLK);
      STEP_FCS:   tgt = PIN_IW'(PIN_FCS);
      STEP_FJOIN: tgt = PIN_IW'(PIN_DJOIN);
      STEP_FSEP:  tgt = PIN_IW'(PIN_DSEP);
      default:    tgt = PIN_IW'(PIN_SDCS);
    endcase
  end

  bp_step_timer #(.SETTLE_W(SETTLE_W), .GAP(CONFIRM_GAP)) u_timer (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .clr_i        (go),
    .in_settle_i  (phase_q == PH_SETTLE),
    .in_gap_i     (phase_q == PH_GAP),
    .settle_lim_i (settle_q),
    .s1_o         (s1),
    .s2_o         (s2)
  );

  bp_pull_confirm u_confirm (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .s1_i   (s1),
    .pin_i  (pin_i[tgt]),
    .hit_o  (hit)
  );

  bp_pin_drive #(.NUM_PINS(NUM_PINS), .PIN_FCS(PIN_FCS)) u_drive (
    .drive_fcs_i ((phase_q == PH_SETTLE || phase_q == PH_GAP) &&
                  (step_q == STEP_FJOIN || step_q == STEP_FSEP)),
    .oe_o        (pin_oe_o),
    .do_o        (pin_do_o)
  );

  // step outcome, resolved at the second sample
  always_comb begin
    nxt_step = step_q;
    fin      = 1'b0;
    fin_src  = SRC_DBG;
    fin_w    = 1'b0;
    unique case (step_q)
      STEP_SER:   if (hit) begin fin = 1'b1; fin_src = SRC_SER; end
                  else nxt_step = STEP_EEP;
      STEP_EEP:   if (hit) begin fin = 1'b1; fin_src = SRC_EEP; end
                  else nxt_step = STEP_FCS;
      STEP_FCS:   nxt_step = hit ? STEP_FJOIN : STEP_SDCS;
      STEP_FJOIN: if (hit) begin fin = 1'b1; fin_src = SRC_FLASH; end
                  else nxt_step = STEP_FSEP;
      STEP_FSEP:  if (hit) begin fin = 1'b1; fin_src = SRC_FLASH; fin_w = 1'b1; end
                  else nxt_step = STEP_SDCS;
      STEP_SDCS:  begin fin = 1'b1; fin_src = hit ? SRC_SD : SRC_DBG; end
      default:    fin = 1'b1;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q  <= PH_IDLE;
      step_q   <= STEP_SER;
      settle_q <= '0;
      src_q    <= '0;
      width_q  <= 1'b0;
    end else begin
      unique case (phase_q)
        PH_IDLE: if (start_i) begin
          phase_q  <= PH_SETTLE;
          step_q   <= STEP_SER;
          settle_q <= settle_i;
        end
        PH_SETTLE: if (s1) phase_q <= PH_GAP;
        PH_GAP: if (s2) begin
          if (fin) begin
            phase_q <= PH_DONE;
            src_q   <= SRC_W'(1) << fin_src;
            width_q <= fin_w;
          end else begin
            step_q  <= nxt_step;
            phase_q <= PH_SETTLE;
          end
        end
        default: ;
      endcase
    end
  end

  assign src_o    = src_q;
  assign width4_o = width_q;
  assign done_o   = (phase_q == PH_DONE);
endmodule

// File: rtl/boot_probe_chk.sv
module boot_probe_chk #(
  parameter int NUM_PINS = 8,
  parameter int PIN_FCS  = 5
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic [NUM_PINS-1:0] pin_oe_o,
  input logic [4:0]          src_o,
  input logic                width4_o,
  input logic                done_o
);
  localparam logic [NUM_PINS-1:0] FCS_MASK = NUM_PINS'(1) << PIN_FCS;

  AST_ONE_SOURCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $countones(src_o) == 1);  // R11
  AST_NO_SOURCE_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> src_o == '0);  // R11
  AST_RESULT_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> done_o && $stable(src_o) && $stable(width4_o));  // R11
  AST_WIDTH_FLASH_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    width4_o |-> src_o[2]);  // R4
  AST_ONLY_FCS_DRIVEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pin_oe_o & ~FCS_MASK) == '0);  // R8
  AST_UNDRIVEN_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> pin_oe_o == '0);  // R8
endmodule

bind boot_probe_seq boot_probe_chk #(.NUM_PINS(NUM_PINS), .PIN_FCS(PIN_FCS)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .pin_oe_o (pin_oe_o),
  .src_o    (src_o),
  .width4_o (width4_o),
  .done_o   (done_o)
);

// File: tb/sim_boot_probe_seq.sv
`timescale 1ns/1ps
module sim_boot_probe_seq;
  localparam int GAP = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [7:0] settle = 8'd2;
  logic [7:0] pins = 8'h00;
  logic [7:0] oe, dout;
  logic [4:0] src;
  logic       w4, done;

  int errs = 0;
  int checks = 0;
  bit mon_busy = 1'b0;

  typedef struct {
    logic [4:0] src;
    logic       w;
    int         lat;
    string      tag;
  } exp_t;
  exp_t q[$];

  always #2 clk = ~clk;

  boot_probe_seq u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .settle_i(settle),
    .pin_i(pins), .pin_oe_o(oe), .pin_do_o(dout), .src_o(src),
    .width4_o(w4), .done_o(done)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // monitor: pops the expected result when a run starts, compares at done
  always begin
    @(posedge clk);
    if (rst_n && start && !done && q.size() > 0) begin
      exp_t e;
      int k;
      mon_busy = 1'b1;
      e = q.pop_front();
      k = 0;
      forever begin
        @(negedge clk);
        if (done || k > 5000) break;
        @(posedge clk);
        k++;
      end
      chk(k == e.lat, {e.tag, " latency"}, k, e.lat);
      chk(src == e.src, {e.tag, " source"}, src, e.src);
      chk(w4 == e.w, {e.tag, " width"}, w4, e.w);
      mon_busy = 1'b0;
    end
  end

  task automatic do_reset(input logic [7:0] p, input int st);
    @(negedge clk);
    rst_n = 1'b0;
    pins = p;
    settle = 8'(st);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  // glitch: 0 none, 1 serial high only at first sample, 2 only at second
  task automatic run_case(input logic [7:0] p, input int st, input logic [4:0] es,
                          input logic ew, input int steps, input string tag,
                          input int glitch, input bit oechk);
    exp_t e;
    int len;
    len = st + 1 + GAP;
    do_reset(p, st);
    e.src = es; e.w = ew; e.lat = steps * len; e.tag = tag;
    q.push_back(e);
    start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    if (glitch != 0) begin
      repeat (st + 1) @(posedge clk);
      @(negedge clk);
      pins[7] = (glitch == 2);
    end
    if (oechk) begin
      chk(oe == 8'h00 && dout == 8'h00, "R8 idle-step drive", oe, 0);
      repeat (2 * len) @(negedge clk);
      chk(oe == 8'h00, "R8 select step undriven", oe, 0);
      repeat (len) @(negedge clk);
      chk(oe == 8'h20 && dout == 8'h00, "R8 flash select driven low", oe, 32);
    end
    @(negedge clk);
    while (mon_busy) @(negedge clk);
  endtask

  initial begin
    #(4 * 150000);
    errs++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errs, checks + 1);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    chk(done == 1'b0 && src == 5'd0 && w4 == 1'b0 && oe == 8'h00, "R12 reset state",
        {done, src, w4}, 0);
    rst_n = 1'b1;

    run_case(8'hF0, 2, 5'b00001, 1'b0, 1, "R1 serial wins", 0, 1'b0);
    run_case(8'h40, 2, 5'b00010, 1'b0, 2, "R2 eeprom", 0, 1'b0);
    run_case(8'h38, 2, 5'b00100, 1'b0, 4, "R3 flash joined", 0, 1'b1);
    run_case(8'h28, 2, 5'b00100, 1'b1, 5, "R4 flash separate", 0, 1'b0);
    run_case(8'h24, 2, 5'b01000, 1'b0, 6, "R5 flash no reply to sd", 0, 1'b0);
    run_case(8'h04, 2, 5'b01000, 1'b0, 4, "R6 sd card", 0, 1'b0);
    run_case(8'h00, 2, 5'b10000, 1'b0, 4, "R7 nothing", 0, 1'b0);
    run_case(8'h20, 2, 5'b10000, 1'b0, 6, "R7 flash select only", 0, 1'b0);
    run_case(8'h40, 0, 5'b00010, 1'b0, 2, "R9 settle zero", 0, 1'b0);
    run_case(8'h18, 11, 5'b10000, 1'b0, 4, "R9 settle eleven R3 data without select", 0, 1'b0);
    run_case(8'hC0, 3, 5'b00010, 1'b0, 2, "R10 first sample only", 1, 1'b0);
    run_case(8'h40, 3, 5'b00010, 1'b0, 2, "R10 second sample only", 2, 1'b0);

    // R11: start after done is ignored, result held
    @(negedge clk);
    pins = 8'h80;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (40) @(negedge clk);
    chk(done == 1'b1, "R11 done held", done, 1);
    chk(src == 5'b00010, "R11 result held after restart", src, 2);
    chk(oe == 8'h00, "R8 undriven after done", oe, 0);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule